// File: doc/BRIEF.md
# General-Purpose I/O Port with Set/Clear Output Control

This block is a 32-pin general-purpose I/O port. It sits on a simple memory-mapped register bus with a write strobe, a read strobe, a word address and one data word. Software picks each pin's direction in a direction register. It changes the output levels only through two write-one registers: one raises the chosen pins and the other lowers them. There is no plain write to the output latch, so software can change any group of pins without a read-modify-write sequence. A pin-value register returns the synchronized level of every pad, whatever the pin's direction.

Each pin also has a 2-bit function-select code that comes from outside the block. The port drives a pin's pad only while that pin's code is 00 and its direction bit is 1. Any other code hands the pad to another function, and the port's output-enable for that pin stays low. The pad inputs pass through a two-flop synchronizer before any read can see them. The word map is: 0 direction (read/write), 1 pin value (read-only), 2 set (write-one-to-set, reads back the output latch), 3 clear (write-one-to-clear, reads back zero).

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset the direction register and the output latch are all zeros. `pad_oe` and `pad_out` are zero, and reads of words 0, 2 and 3 return zero.
- R2: Word 0 is the direction register and can be read and written. Bit i set to 1 makes pin i an output; a 0 makes it an input.
- R3: `pad_oe[i]` is high exactly when direction bit i is 1 and `func_sel[2i+1:2i]` equals 2'b00.
- R4: A write to word 2 sets every latch bit whose data bit is 1. Bits written as 0 keep their value. The change shows on `pad_out` in the cycle after the write.
- R5: A write to word 3 clears every latch bit whose data bit is 1, and bits written as 0 keep their value. A read of word 2 returns the current latch, so a cleared bit reads back as 0. A read of word 3 always returns zero.
- R6: A read of word 1 returns the pad inputs after two synchronizer stages. A change on `pad_in` before clock edge k is captured by a read issued at edge k+2, but not by a read issued at edge k+1.
- R7: A read has one cycle of latency. `rdata` takes the addressed value at the edge where `rd_en` is high. After an edge where `rd_en` is low, `rdata` is zero.
- R8: Writes to word 1 and to words 4 to 7 change nothing. Reads of words 4 to 7 return zero.
- R9: `pad_out` always shows the output latch, whatever the direction bit and the function-select code.
- R10: Reads, and cycles without a set or clear write, leave the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| func_sel | input | 64 | Two select bits per pin; 00 gives the pin to this port |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch toward the pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
Assertions check every cycle that:
- a set write raises the written bits on `pad_out` in the next cycle;
- a clear write lowers them in the next cycle;
- `pad_out` holds when no set or clear write takes place;
- a direction write leaves no output-enable for a bit written as 0;
- reads of the clear word, and cycles without a read, return zero.

Other behaviours can only be shown by the bench's scenarios, because they depend on a sequence of stimulus: the exact two-edge delay of the synchronizer, the masking of the output-enable by non-zero select codes, and the fact that writes to the pin-value word and to unmapped words change nothing. A behavioural reference model compares every output on every clock through both directed and random traffic.

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NPINS-1:0]     wdata,
  output logic [NPINS-1:0]     rdata,
  input  logic [2*NPINS-1:0]   func_sel,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe
);

  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3);

  logic [NPINS-1:0] dir_q, lat_q, sync1_q, sync2_q, gpio_own, rd_mux;

  for (genvar i = 0; i < NPINS; i++) begin : g_own
    assign gpio_own[i] = (func_sel[2*i +: 2] == 2'b00);
  end

  assign pad_oe  = dir_q & gpio_own;
  assign pad_out = lat_q;

  always_comb begin
    case (addr)
      A_DIR:   rd_mux = dir_q;
      A_PIN:   rd_mux = sync2_q;
      A_SET:   rd_mux = lat_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      rdata   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (wr_en && addr == A_DIR) dir_q <= wdata;
      if (wr_en && addr == A_SET)      lat_q <= lat_q | wdata;
      else if (wr_en && addr == A_CLR) lat_q <= lat_q & ~wdata;
      rdata <= rd_en ? rd_mux : '0;
    end
  end

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((pad_out & $past(wdata)) == $past(wdata)));

  assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((pad_out & $past(wdata)) == '0));

  assert_clr_rd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CLR) |=> (rdata == '0));

  assert_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> ((pad_oe & ~$past(wdata)) == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_SET || addr == A_CLR)) |=> $stable(pad_out));

  assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

endmodule

// File: tb/tb_gpio_setclr_port.sv
`timescale 1ns/1ps
module tb_gpio_setclr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic [63:0] fs = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_dir, m_lat, m_s1, m_s2, m_rd;

  gpio_setclr_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .func_sel(fs), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] exp_oe();
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = m_dir[i] && (fs[2*i +: 2] == 2'b00);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic model_edge(bit w, bit r, logic [2:0] a, logic [31:0] d);
    logic [31:0] nrd;
    nrd = 32'h0;
    if (r) begin
      if (a == 3'd0) nrd = m_dir;
      else if (a == 3'd1) nrd = m_s2;
      else if (a == 3'd2) nrd = m_lat;
    end
    if (w && a == 3'd0) m_dir = d;
    if (w && a == 3'd2) m_lat = m_lat | d;
    if (w && a == 3'd3) m_lat = m_lat & ~d;
    m_s2 = m_s1;
    m_s1 = pad_in;
    m_rd = nrd;
  endtask

  task automatic step(bit w, bit r, logic [2:0] a, logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    model_edge(w, r, a, d);
    @(negedge clk);
    chk("R3 pad_oe", pad_oe, exp_oe());
    chk("R9 pad_out", pad_out, m_lat);
    chk("R7 rdata", rdata, m_rd);
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_dir = '0; m_lat = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    step(0, 1, 3'd0, 0); chk("R1 dir read", rdata, 32'h0);
    step(0, 1, 3'd2, 0); chk("R1 set read", rdata, 32'h0);
    step(0, 1, 3'd3, 0); chk("R1 clr read", rdata, 32'h0);

    // R2 direction
    step(1, 0, 3'd0, 32'hFFFF_0000);
    step(0, 1, 3'd0, 0); chk("R2 dir read", rdata, 32'hFFFF_0000);
    chk("R2 oe", pad_oe, 32'hFFFF_0000);

    // R3 select masking
    fs[33:32] = 2'b01; fs[63:62] = 2'b11;
    step(0, 0, 3'd0, 0); chk("R3 masked oe", pad_oe, 32'h7FFE_0000);
    fs = '0;
    step(0, 0, 3'd0, 0); chk("R3 unmasked oe", pad_oe, 32'hFFFF_0000);

    // R4 set
    step(1, 0, 3'd2, 32'h0000_00F0); chk("R4 set", pad_out, 32'h0000_00F0);
    step(1, 0, 3'd2, 32'h0F00_000F); chk("R4 zeros keep", pad_out, 32'h0F00_00FF);

    // R5 clear
    step(1, 0, 3'd3, 32'h0000_0011); chk("R5 clear", pad_out, 32'h0F00_00EE);
    step(0, 1, 3'd2, 0); chk("R5 set readback", rdata, 32'h0F00_00EE);
    step(0, 1, 3'd3, 0); chk("R5 clr reads zero", rdata, 32'h0);

    // R8 ignored writes
    step(1, 0, 3'd1, 32'hFFFF_FFFF);
    step(1, 0, 3'd5, 32'hFFFF_FFFF);
    step(1, 0, 3'd7, 32'h0000_FFFF);
    step(0, 1, 3'd0, 0); chk("R8 dir intact", rdata, 32'hFFFF_0000);
    step(0, 1, 3'd2, 0); chk("R8 latch intact", rdata, 32'h0F00_00EE);
    step(0, 1, 3'd6, 0); chk("R8 unmapped read", rdata, 32'h0);

    // R6 synchronizer delay
    pad_in = 32'hA5A5_0F0F;
    step(0, 0, 3'd0, 0);
    step(0, 1, 3'd1, 0); chk("R6 one edge", rdata, 32'h0);
    step(0, 1, 3'd1, 0); chk("R6 two edges", rdata, 32'hA5A5_0F0F);

    // R7 latency / idle zero
    step(0, 1, 3'd0, 0); chk("R7 read", rdata, 32'hFFFF_0000);
    step(0, 0, 3'd0, 0); chk("R7 idle zero", rdata, 32'h0);

    // R10 reads keep latch
    step(0, 1, 3'd2, 0);
    step(0, 1, 3'd1, 0);
    chk("R10 latch held", pad_out, 32'h0F00_00EE);

    // random traffic against model
    for (int n = 0; n < 600; n++) begin
      pad_in = $urandom;
      if ($urandom_range(0, 7) == 0) fs = {$urandom, $urandom};
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           3'($urandom_range(0, 7)), $urandom);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule